// File: doc/BRIEF.md
# Dual-Issue Grouping Counter

This block estimates how a stream of retiring instructions would pack into a two-wide issue machine. Each instruction arrives with a valid strobe, a 4-bit functional-unit class code and a flag. The flag is set when the instruction depends on the one before it. For each instruction the block decides whether it joins the issue group already open or opens a new one. It keeps running totals of issue cycles, of cycles opened because of a dependence, and of loads and stores.

The grouping rule uses one credit count per unit class and a shared slot budget. When a new group opens, every class is refilled with its own credit allowance and the slot budget is set back to two. The incoming instruction then spends one credit of its class and one slot. Compare, branch and jump may appear only once per group. Every other class may appear twice, so for those classes only the slot budget limits the group. The class decoder and the dependence check sit upstream and are not part of this block.

Top module: `issue_group_ctr`

## Requirements
- R1: While reset is active and at the first edge after it, all four counters read zero and the new-cycle pulse is low. The block leaves reset with every class at its full allowance and two free slots, so the first instruction after reset without the dependence flag does not open a cycle.
- R2: The slot budget is 2 per group. A third instruction presented without the dependence flag, whose class still has credit, opens a new cycle because no slot is left.
- R3: Class codes 3 (compare), 4 (branch) and 5 (jump) hold one credit per group. A second instruction of the same one of these classes in a group opens a new cycle.
- R4: Class codes 0 (unknown), 1 (arithmetic), 2 (shift), 6 (extend), 7 (nop), 8 (move), 9 (move-immediate), 10 (load) and 11 (store) hold two credits per group. Two arithmetic instructions in a row share one group.
- R5: An accepted instruction with the dependence flag set always opens a new cycle, even when credit and slots remain.
- R6: For every accepted instruction that opens a new cycle, `new_cycle` is high for exactly the one clock after the accepting edge. The cycle counter also rises by one at that accepting edge.
- R7: The dependence-wait counter rises by one only when a new cycle is opened while the dependence flag is set. A new cycle caused only by lack of credit or slots leaves it unchanged.
- R8: After a group is refilled, the instruction that opened it spends one credit of its class and one slot. A compare that opens a group therefore forces the next compare to open another, while a branch may still join it.
- R9: An accepted class 10 instruction adds one to the load counter, and an accepted class 11 instruction adds one to the store counter. No other class changes either counter.
- R10: Class codes 12 to 15 are treated as the unknown class. They hold two credits, so two of them in a row share a group, and they change neither the load counter nor the store counter.
- R11: A cycle without the valid strobe changes no counter, no credit and no slot, whatever the class and flag inputs carry. `new_cycle` is low in the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_class | input | 4 | Functional-unit class code of the instruction |
| in_hazard | input | 1 | The instruction depends on the previous one |
| new_cycle | output | 1 | The instruction accepted at the previous edge opened a new cycle |
| cycle_count | output | CNT_W | Number of issue cycles opened |
| hazard_count | output | CNT_W | Number of cycles opened with the dependence flag set |
| load_count | output | CNT_W | Number of load instructions accepted |
| store_count | output | CNT_W | Number of store instructions accepted |

## Verification
Credits and the slot budget are not visible at the ports. A wrong value in either one shows up only through `new_cycle`. The next instruction of the affected class then opens a cycle when it should have joined, or the reverse, and the cycle counter moves away from the expected total one clock later. For this reason the stimulus places instructions from one-credit classes and two-credit classes so that a missing or extra credit changes the grouping within two instructions. Idle cycles with non-zero flag and class inputs are placed right before instructions whose grouping depends on the state being kept, so that any state wrongly taken by an idle cycle shows up at the next accepted instruction.

// File: rtl/issue_group_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the issue grouping counter.
// Assumes class codes at or above NUM_CLASSES are folded onto CLS_UNKNOWN upstream of the credit bank.
package issue_group_pkg;

    localparam int CLASS_W     = 4;
    localparam int NUM_CLASSES = 12;
    localparam int CREDIT_W    = 2;

    typedef enum logic [CLASS_W-1:0] {
        CLS_UNKNOWN = 4'd0,
        CLS_ARITH   = 4'd1,
        CLS_SHIFT   = 4'd2,
        CLS_COMPARE = 4'd3,
        CLS_BRANCH  = 4'd4,
        CLS_JUMP    = 4'd5,
        CLS_EXTEND  = 4'd6,
        CLS_NOP     = 4'd7,
        CLS_MOVE    = 4'd8,
        CLS_MOVIMM  = 4'd9,
        CLS_LOAD    = 4'd10,
        CLS_STORE   = 4'd11
    } unit_class_e;

    // Credit allowance a class receives whenever a new group opens.
    function automatic int refill_credit(input int cls);
        if (cls == int'(CLS_COMPARE) || cls == int'(CLS_BRANCH) || cls == int'(CLS_JUMP))
            return 1;
        return 2;
    endfunction

endpackage

// File: rtl/ig_class_map.sv
`timescale 1ns/1ps
// Folds the raw class code onto a credit-bank index and flags memory classes.
// Assumes nothing about the code: any value above the last defined class becomes unknown.
module ig_class_map
    import issue_group_pkg::*;
(
    input  logic [CLASS_W-1:0] code,
    output logic [CLASS_W-1:0] idx,
    output logic               is_load,
    output logic               is_store
);

    // Map the code, folding undefined values onto the unknown class.
    always_comb begin
        if (int'(code) < NUM_CLASSES)
            idx = code;
        else
            idx = CLS_UNKNOWN;
        is_load  = (idx == CLS_LOAD);
        is_store = (idx == CLS_STORE);
    end

endmodule

// File: rtl/ig_credit_bank.sv
`timescale 1ns/1ps
// Holds one credit count per unit class and reports whether the addressed class still has credit.
// Assumes idx is already folded below NUM_CLASSES and that refill is raised whenever the
// addressed class is empty, so a credit never decrements from zero.
module ig_credit_bank
    import issue_group_pkg::*;
#(
    parameter int N_CLS = NUM_CLASSES,
    parameter int CR_W  = CREDIT_W,
    parameter int IDX_W = CLASS_W
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             refill,
    input  logic [IDX_W-1:0] idx,
    output logic             has_credit
);

    logic [N_CLS-1:0] hit_vec;
    logic [N_CLS-1:0] live_vec;

    for (genvar c = 0; c < N_CLS; c++) begin : g_cls
        localparam logic [CR_W-1:0] FULL = CR_W'(refill_credit(c));
        logic [CR_W-1:0] credit_q;

        assign hit_vec[c]  = (idx == IDX_W'(c));
        assign live_vec[c] = (credit_q != '0);

        // Refill on a new group, then charge the accepted class one credit.
        always_ff @(posedge clk) begin
            if (!rst_n)
                credit_q <= FULL;
            else if (take) begin
                if (refill)
                    credit_q <= hit_vec[c] ? FULL - 1'b1 : FULL;
                else if (hit_vec[c])
                    credit_q <= credit_q - 1'b1;
            end
        end

        // R3
        credit_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            credit_q <= FULL);
        // R8
        credit_charge_chk: assert property (@(posedge clk) disable iff (!rst_n)
            take && hit_vec[c] |=> credit_q < FULL);
    end

    // Select the liveness of the addressed class.
    always_comb has_credit = |(hit_vec & live_vec);

endmodule

// File: rtl/ig_event_counters.sv
`timescale 1ns/1ps
// Keeps the cycle, dependence-wait, load and store totals and the registered new-cycle pulse.
// Assumes start is meaningful only when take is high. Counters wrap at their width.
module ig_event_counters #(
    parameter int CNT_W = 16
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             start,
    input  logic             hazard,
    input  logic             is_load,
    input  logic             is_store,
    output logic             new_cycle,
    output logic [CNT_W-1:0] cycles,
    output logic [CNT_W-1:0] hazards,
    output logic [CNT_W-1:0] loads,
    output logic [CNT_W-1:0] stores
);

    // Update the totals and the one-clock pulse from each accepted instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            new_cycle <= 1'b0;
            cycles    <= '0;
            hazards   <= '0;
            loads     <= '0;
            stores    <= '0;
        end else begin
            new_cycle <= take && start;
            if (take && start)            cycles  <= cycles + 1'b1;
            if (take && start && hazard)  hazards <= hazards + 1'b1;
            if (take && is_load)          loads   <= loads + 1'b1;
            if (take && is_store)         stores  <= stores + 1'b1;
        end
    end

    // R6
    cycle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        new_cycle |-> cycles == $past(cycles) + 1'b1);
    // R7
    hazard_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hazards != $past(hazards) |-> new_cycle);
    // R9
    mem_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(loads != $past(loads) && stores != $past(stores)));

endmodule

// File: rtl/issue_group_ctr.sv
`timescale 1ns/1ps
// Top of the dual-issue grouping counter. It decides, for each accepted instruction, whether
// a new issue group opens, holds the shared slot budget, and feeds the credit bank and counters.
// Assumes the class code and dependence flag are stable with in_valid at the sampling edge.
module issue_group_ctr
    import issue_group_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SLOT_BUDGET = 2
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [3:0]       in_class,
    input  logic             in_hazard,
    output logic             new_cycle,
    output logic [CNT_W-1:0] cycle_count,
    output logic [CNT_W-1:0] hazard_count,
    output logic [CNT_W-1:0] load_count,
    output logic [CNT_W-1:0] store_count
);

    localparam int SLOT_W = $clog2(SLOT_BUDGET + 1);
    localparam logic [SLOT_W-1:0] SLOT_FULL = SLOT_W'(SLOT_BUDGET);

    logic [CLASS_W-1:0] cls_idx;
    logic               cls_load;
    logic               cls_store;
    logic               cls_live;
    logic               open_group;
    logic [SLOT_W-1:0]  slots_q;

    ig_class_map u_map (
        .code     (in_class),
        .idx      (cls_idx),
        .is_load  (cls_load),
        .is_store (cls_store)
    );

    ig_credit_bank #(
        .N_CLS (NUM_CLASSES),
        .CR_W  (CREDIT_W),
        .IDX_W (CLASS_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (in_valid),
        .refill     (open_group),
        .idx        (cls_idx),
        .has_credit (cls_live)
    );

    // Decide whether the presented instruction must open a new group.
    always_comb open_group = in_hazard || !cls_live || (slots_q == '0);

    // Track the shared slot budget: reload on a new group, then spend one slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            slots_q <= SLOT_FULL;
        else if (in_valid)
            slots_q <= open_group ? SLOT_FULL - 1'b1 : slots_q - 1'b1;
    end

    ig_event_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (in_valid),
        .start    (open_group),
        .hazard   (in_hazard),
        .is_load  (cls_load),
        .is_store (cls_store),
        .new_cycle(new_cycle),
        .cycles   (cycle_count),
        .hazards  (hazard_count),
        .loads    (load_count),
        .stores   (store_count)
    );

    // R2
    slot_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slots_q < SLOT_FULL || !$past(in_valid));
    // R5
    hazard_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_hazard |=> new_cycle);
    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !new_cycle && $stable(cycle_count) && $stable(hazard_count)
                      && $stable(load_count) && $stable(store_count) && $stable(slots_q));

endmodule

// File: tb/test_issue_group_ctr.sv
`timescale 1ns/1ps
// Scoreboard bench: a driver models the grouping rules from the requirements and queues the
// expected port values; a monitor compares them 2 ns after each rising edge.
module test_issue_group_ctr;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_class = 4'd0;
    logic        in_hazard = 1'b0;
    logic        new_cycle;
    logic [15:0] cycle_count, hazard_count, load_count, store_count;

    always #4 clk = ~clk;

    issue_group_ctr i_issue_group_ctr (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
        .in_hazard(in_hazard), .new_cycle(new_cycle), .cycle_count(cycle_count),
        .hazard_count(hazard_count), .load_count(load_count), .store_count(store_count)
    );

    typedef struct {
        logic        nc;
        logic [15:0] cyc, haz, ld, st;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   finished = 0;

    // Reference state kept by the driver
    int          m_cred[12];
    int          m_slots;
    logic [15:0] m_cyc, m_haz, m_ld, m_st;

    function automatic int full_of(input int c);
        return (c == 3 || c == 4 || c == 5) ? 1 : 2;
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 12; c++) m_cred[c] = full_of(c);
        m_slots = 2;
        m_cyc = 0; m_haz = 0; m_ld = 0; m_st = 0;
    endtask

    task automatic check(input string tag, input logic nc, input logic [15:0] cyc,
                         input logic [15:0] haz, input logic [15:0] ld, input logic [15:0] st);
        n_checks++;
        if (new_cycle !== nc || cycle_count !== cyc || hazard_count !== haz ||
            load_count !== ld || store_count !== st) begin
            n_fail++;
            $display("FAIL %s: actual nc=%0b cyc=%0d haz=%0d ld=%0d st=%0d expected nc=%0b cyc=%0d haz=%0d ld=%0d st=%0d",
                     tag, new_cycle, cycle_count, hazard_count, load_count, store_count,
                     nc, cyc, haz, ld, st);
        end
    endtask

    // Present one instruction and queue what the ports must show after the edge.
    task automatic issue(input logic [3:0] code, input logic hz, input string tag);
        exp_t e;
        int   ci;
        bit   start;
        @(negedge clk);
        ci = (code > 11) ? 0 : int'(code);
        start = hz || (m_cred[ci] < 1) || (m_slots < 1);
        if (start) begin
            for (int c = 0; c < 12; c++) m_cred[c] = full_of(c);
            m_slots = 2;
            m_cyc++;
            if (hz) m_haz++;
        end
        m_cred[ci]--;
        m_slots--;
        if (ci == 10) m_ld++;
        if (ci == 11) m_st++;
        in_valid = 1'b1; in_class = code; in_hazard = hz;
        e.nc = start; e.cyc = m_cyc; e.haz = m_haz; e.ld = m_ld; e.st = m_st; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Idle cycle with arbitrary non-zero side inputs.
    task automatic idle(input logic [3:0] code, input logic hz, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b0; in_class = code; in_hazard = hz;
        e.nc = 1'b0; e.cyc = m_cyc; e.haz = m_haz; e.ld = m_ld; e.st = m_st; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compare queued expectations shortly after each rising edge.
    always begin
        @(posedge clk);
        #2;
        if (rst_n && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.tag, e.nc, e.cyc, e.haz, e.ld, e.st);
        end
    end

    // Watchdog
    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R1: counters and pulse are clear during reset
        check("R1 in reset", 1'b0, 16'd0, 16'd0, 16'd0, 16'd0);
        rst_n = 1'b1;
        @(posedge clk); #2;
        check("R1 after release", 1'b0, 16'd0, 16'd0, 16'd0, 16'd0);

        issue(4'd1,  1'b0, "R1 first arith joins");
        issue(4'd1,  1'b0, "R4 second arith joins");
        issue(4'd10, 1'b0, "R2 slot budget spent");
        issue(4'd11, 1'b0, "R9 store joins load group");
        issue(4'd3,  1'b0, "R2 compare opens on slots");
        issue(4'd3,  1'b0, "R3 second compare opens");
        issue(4'd4,  1'b0, "R8 branch joins compare group");
        idle(4'd3, 1'b1, "R11 idle with flag");
        idle(4'd15, 1'b1, "R11 idle with code 15");
        idle(4'd10, 1'b0, "R11 idle with load code");
        issue(4'd5,  1'b0, "R11 state held: jump opens on slots");
        issue(4'd2,  1'b1, "R5 dependence opens cycle");
        issue(4'd14, 1'b0, "R10 code 14 joins");
        issue(4'd1,  1'b1, "R7 dependence wait counted");
        issue(4'd13, 1'b0, "R10 code 13 joins");
        issue(4'd15, 1'b0, "R10 code 15 opens on slots");
        issue(4'd12, 1'b0, "R10 code 12 joins as unknown");
        issue(4'd5,  1'b0, "R7 slot-only open not counted");
        issue(4'd5,  1'b0, "R3 second jump opens");
        issue(4'd9,  1'b0, "R4 move-imm joins");
        issue(4'd10, 1'b0, "R9 load counted");
        issue(4'd11, 1'b0, "R9 store counted");

        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 4) == 0)
                idle(4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)), "R11 random idle");
            else
                issue(4'($urandom_range(0, 15)), ($urandom_range(0, 3) == 0), "R6 random stream");
        end

        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(posedge clk);
        #3;
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule